// File: doc/BRIEF.md
# Shift-Rotate Unit with T Flag

This block is the shift and rotate part of a small RISC integer datapath. It is purely combinational. It takes an operand word, a second word used as a signed shift amount, the current T (carry/test) bit and a 4-bit operation code. It returns the new result word and the new T bit in the same cycle. The operations are:

- plain rotates, and rotates that pass through T;
- one-bit shifts that move the bit shifted out into T;
- fixed logical shifts by 2, 8 and 16;
- dynamic shifts whose direction comes from the sign of the amount word.

The unit holds no state, so it has no states or transitions to list. The surrounding pipeline registers its inputs and outputs. The register file, decode and memory access sit outside the block.

Top module: `sr_shift_unit`

## Requirements
- R1: Code 1 (rotate left) gives result {opnd[30:0], opnd[31]} and T = opnd[31]. Code 2 (rotate right) gives {opnd[0], opnd[31:1]} and T = opnd[0].
- R2: Code 3 (rotate left through T) gives {opnd[30:0], T_in} and T = opnd[31]. Code 4 (rotate right through T) gives {T_in, opnd[31:1]} and T = opnd[0].
- R3: Code 5 (one-bit left shift) gives opnd << 1 with a zero fill, and T = opnd[31].
- R4: Code 6 (one-bit arithmetic right) keeps opnd[31] as the sign and gives T = opnd[0]. Code 7 (one-bit logical right) fills with zero and gives T = opnd[0].
- R5: Codes 8/9 shift left/right by 2, codes 10/11 by 8, and codes 12/13 by 16. All six are logical, and T_out equals T_in.
- R6: For codes 14 and 15, when amt[31] is 0 the result is opnd << amt[4:0]. Amount bits 30..5 have no effect.
- R7: For codes 14 and 15, when amt[31] is 1 and amt[4:0] is not zero, the operand shifts right by 32 - amt[4:0] (range 1..31). Code 14 fills with the sign bit and code 15 fills with zero.
- R8: When amt[31] is 1 and amt[4:0] is zero, code 14 returns 32 copies of opnd[31] and code 15 returns zero.
- R9: Codes 14 and 15 leave T unchanged (T_out = T_in).
- R10: Code 0 is unused. It passes the operand to the result and T_in to T_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Operand word to shift or rotate |
| amt_i | input | 32 | Signed dynamic shift amount (codes 14, 15) |
| t_i | input | 1 | Current T bit |
| op_i | input | 4 | Operation code |
| res_o | output | 32 | Result word |
| t_o | output | 1 | New T bit |

## Verification
The bench targets the negative amounts whose low five bits are zero. A design that reused the ordinary right path there would return the operand unchanged instead of a sign fill or zero. It also uses amounts of -1 and -31 and amounts with stray middle bits set. These catch an off-by-one in the two's-complement magnitude and any decode that looks past bit 4. Rotates through T are run with both T values and with the edge bits set. A design that swapped old T and the shifted-out bit would then show the wrong bit in position 0 or 31. Each fixed and dynamic shift is also run with T set, so a design that clobbered T is caught.

// File: rtl/sr_pkg.sv
package sr_pkg;
    typedef enum logic [3:0] {
        OP_PASS  = 4'd0,
        OP_ROTL  = 4'd1,
        OP_ROTR  = 4'd2,
        OP_ROTCL = 4'd3,
        OP_ROTCR = 4'd4,
        OP_SHL1  = 4'd5,
        OP_SAR1  = 4'd6,
        OP_SHR1  = 4'd7,
        OP_SHL2  = 4'd8,
        OP_SHR2  = 4'd9,
        OP_SHL8  = 4'd10,
        OP_SHR8  = 4'd11,
        OP_SHL16 = 4'd12,
        OP_SHR16 = 4'd13,
        OP_DSHA  = 4'd14,
        OP_DSHL  = 4'd15
    } sr_op_e;

    function automatic logic is_rotate(input sr_op_e op);
        return (op == OP_ROTL) || (op == OP_ROTR) || (op == OP_ROTCL) || (op == OP_ROTCR);
    endfunction

    function automatic logic is_dynamic(input sr_op_e op);
        return (op == OP_DSHA) || (op == OP_DSHL);
    endfunction
endpackage

// File: rtl/sr_rotate_unit.sv
module sr_rotate_unit
    import sr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opnd,
    input  logic         t_in,
    input  sr_op_e       op,
    output logic [W-1:0] res,
    output logic         t_out
);
    always_comb begin
        res   = opnd;
        t_out = t_in;
        unique case (op)
            OP_ROTL: begin
                res   = {opnd[W-2:0], opnd[W-1]};
                t_out = opnd[W-1];
            end
            OP_ROTR: begin
                res   = {opnd[0], opnd[W-1:1]};
                t_out = opnd[0];
            end
            OP_ROTCL: begin
                res   = {opnd[W-2:0], t_in};
                t_out = opnd[W-1];
            end
            OP_ROTCR: begin
                res   = {t_in, opnd[W-1:1]};
                t_out = opnd[0];
            end
            default: begin
                res   = opnd;
                t_out = t_in;
            end
        endcase
    end

    // plain rotates keep the bit count; through-T rotates conserve bits plus T
    always_comb begin
        if (op == OP_ROTL || op == OP_ROTR) begin
            p_rot_bits_kept_r1: assert ($countones(res) == $countones(opnd));
        end
        if (op == OP_ROTCL || op == OP_ROTCR) begin
            p_rotc_bits_kept_r2: assert ($countones({res, t_out}) == $countones({opnd, t_in}));
        end
    end
endmodule

// File: rtl/sr_step_shift.sv
module sr_step_shift
    import sr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opnd,
    input  logic         t_in,
    input  sr_op_e       op,
    output logic [W-1:0] res,
    output logic         t_out
);
    localparam int S_A = 2;
    localparam int S_B = 8;
    localparam int S_C = 16;

    always_comb begin
        res   = opnd;
        t_out = t_in;
        unique case (op)
            OP_SHL1: begin
                res   = opnd << 1;
                t_out = opnd[W-1];
            end
            OP_SAR1: begin
                res   = {opnd[W-1], opnd[W-1:1]};
                t_out = opnd[0];
            end
            OP_SHR1: begin
                res   = opnd >> 1;
                t_out = opnd[0];
            end
            OP_SHL2:  res = opnd << S_A;
            OP_SHR2:  res = opnd >> S_A;
            OP_SHL8:  res = opnd << S_B;
            OP_SHR8:  res = opnd >> S_B;
            OP_SHL16: res = opnd << S_C;
            OP_SHR16: res = opnd >> S_C;
            default: begin
                res   = opnd;
                t_out = t_in;
            end
        endcase
    end

    always_comb begin
        if (op == OP_SAR1) begin
            p_sar_sign_r4: assert (res[W-1] == opnd[W-1] && res[W-2] == opnd[W-1]);
        end
        if (op == OP_SHR1) begin
            p_shr_zero_fill_r4: assert (res[W-1] == 1'b0);
        end
        if (op == OP_SHL16) begin
            p_shl16_low_clear_r5: assert (res[S_C-1:0] == '0);
        end
        if (op == OP_SHR16) begin
            p_shr16_high_clear_r5: assert (res[W-1:W-S_C] == '0);
        end
    end
endmodule

// File: rtl/sr_dyn_shift.sv
module sr_dyn_shift #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  opnd,
    input  logic          neg,
    input  logic [SW-1:0] mag,
    input  logic          arith,
    output logic [W-1:0]  res
);
    logic [SW-1:0] rcnt;
    logic          full_fill;
    logic [W-1:0]  lstage [SW+1];
    logic [W-1:0]  rstage [SW+1];

    assign rcnt      = (~mag) + 1'b1;
    assign full_fill = (mag == '0);
    assign lstage[0] = opnd;
    assign rstage[0] = opnd;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        assign lstage[k+1] = rcnt_sel_left(k) ? (lstage[k] << (1 << k)) : lstage[k];
        assign rstage[k+1] = !rcnt[k] ? rstage[k]
                           : (arith ? W'($signed(rstage[k]) >>> (1 << k))
                                    : (rstage[k] >> (1 << k)));
    end

    function automatic logic rcnt_sel_left(input int idx);
        return mag[idx];
    endfunction

    always_comb begin
        if (!neg) begin
            res = lstage[SW];
        end else if (full_fill) begin
            res = arith ? {W{opnd[W-1]}} : '0;
        end else begin
            res = rstage[SW];
        end
    end

    always_comb begin
        if (neg && full_fill && !arith) begin
            p_dyn_zero_logic_r8: assert (res == '0);
        end
        if (neg && !full_fill && !arith) begin
            p_dyn_right_top_clear_r7: assert (res[W-1] == 1'b0);
        end
        if (!neg && mag == '0) begin
            p_dyn_left_zero_ident_r6: assert (res == opnd);
        end
    end
endmodule

// File: rtl/sr_shift_unit.sv
module sr_shift_unit
    import sr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opnd_i,
    input  logic [W-1:0] amt_i,
    input  logic         t_i,
    input  logic [3:0]   op_i,
    output logic [W-1:0] res_o,
    output logic         t_o
);
    localparam int SW = $clog2(W);

    sr_op_e       op;
    logic [W-1:0] rot_res, stp_res, dyn_res;
    logic         rot_t, stp_t;

    assign op = sr_op_e'(op_i);

    sr_rotate_unit #(.W(W)) u_rot (
        .opnd (opnd_i),
        .t_in (t_i),
        .op   (op),
        .res  (rot_res),
        .t_out(rot_t)
    );

    sr_step_shift #(.W(W)) u_step (
        .opnd (opnd_i),
        .t_in (t_i),
        .op   (op),
        .res  (stp_res),
        .t_out(stp_t)
    );

    sr_dyn_shift #(.W(W), .SW(SW)) u_dyn (
        .opnd (opnd_i),
        .neg  (amt_i[W-1]),
        .mag  (amt_i[SW-1:0]),
        .arith(op == OP_DSHA),
        .res  (dyn_res)
    );

    always_comb begin
        if (op == OP_PASS) begin
            res_o = opnd_i;
            t_o   = t_i;
        end else if (is_rotate(op)) begin
            res_o = rot_res;
            t_o   = rot_t;
        end else if (is_dynamic(op)) begin
            res_o = dyn_res;
            t_o   = t_i;
        end else begin
            res_o = stp_res;
            t_o   = stp_t;
        end
    end

    always_comb begin
        if (is_dynamic(op)) begin
            p_dyn_keeps_t_r9: assert (t_o == t_i);
        end
        if (op >= OP_SHL2 && op <= OP_SHR16) begin
            p_fixed_keeps_t_r5: assert (t_o == t_i);
        end
        if (op == OP_PASS) begin
            p_pass_through_r10: assert (res_o == opnd_i && t_o == t_i);
        end
        if (op == OP_SHL1) begin
            p_shl1_t_r3: assert (t_o == opnd_i[W-1] && res_o[0] == 1'b0);
        end
    end
endmodule

// File: tb/sim_sr_shift_unit.sv
module sim_sr_shift_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opnd_i, amt_i, res_o;
    logic        t_i, t_o;
    logic [3:0]  op_i;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    typedef struct {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] m;
        logic        t;
        logic [31:0] er;
        logic        et;
    } item_t;

    item_t sb[$];

    always #2.5 clk = ~clk;

    sr_shift_unit u0 (
        .opnd_i(opnd_i), .amt_i(amt_i), .t_i(t_i), .op_i(op_i),
        .res_o(res_o), .t_o(t_o)
    );

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0:         return "R10";
            4'd1, 4'd2:   return "R1";
            4'd3, 4'd4:   return "R2";
            4'd5:         return "R3";
            4'd6, 4'd7:   return "R4";
            4'd14, 4'd15: return "R6/R7/R8/R9";
            default:      return "R5";
        endcase
    endfunction

    // reference model written from the requirement text
    function automatic logic [32:0] model(input logic [3:0] op, input logic [31:0] a,
                                          input logic [31:0] m, input logic t);
        logic [31:0] r;
        logic        nt;
        int          n;
        r  = a;
        nt = t;
        case (op)
            4'd1:  begin r = (a << 1) | (a >> 31); nt = a[31]; end
            4'd2:  begin r = (a >> 1) | (a << 31); nt = a[0];  end
            4'd3:  begin r = (a << 1) | {31'd0, t}; nt = a[31]; end
            4'd4:  begin r = (a >> 1) | {t, 31'd0}; nt = a[0];  end
            4'd5:  begin r = a * 2; nt = a[31]; end
            4'd6:  begin r = 32'($signed(a) / 2); if (a[31] && a[0]) r = r - 1; nt = a[0]; end
            4'd7:  begin r = a / 2; nt = a[0]; end
            4'd8:  r = a * 4;
            4'd9:  r = a / 4;
            4'd10: r = a * 256;
            4'd11: r = a / 256;
            4'd12: r = a * 65536;
            4'd13: r = a / 65536;
            4'd14, 4'd15: begin
                if (!m[31]) begin
                    r = a << m[4:0];
                end else if (m[4:0] == 5'd0) begin
                    r = (op == 4'd14 && a[31]) ? 32'hFFFF_FFFF : 32'h0;
                end else begin
                    n = 32 - int'(m[4:0]);
                    r = (op == 4'd14) ? 32'($signed(a) >>> n) : (a >> n);
                end
            end
            default: ;
        endcase
        return {nt, r};
    endfunction

    task automatic drive(input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] m, input logic t);
        item_t it;
        logic [32:0] e;
        @(negedge clk);
        op_i = op; opnd_i = a; amt_i = m; t_i = t;
        e = model(op, a, m, t);
        it.op = op; it.a = a; it.m = m; it.t = t; it.er = e[31:0]; it.et = e[32];
        sb.push_back(it);
    endtask

    always @(posedge clk) begin
        if (!rst && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            total++;
            if (res_o !== it.er || t_o !== it.et) begin
                bad++;
                $display("FAIL %s op=%0d a=%h m=%h t=%b: got res=%h t=%b expected res=%h t=%b",
                         req_of(it.op), it.op, it.a, it.m, it.t, res_o, t_o, it.er, it.et);
            end
        end
    end

    initial begin
        logic [31:0] x;
        op_i = 4'd0; opnd_i = 32'h0; amt_i = 32'h0; t_i = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R10: reset state / pass-through for the unused code
        drive(4'd0, 32'hDEAD_BEEF, 32'h0, 1'b1);
        drive(4'd0, 32'h1234_5678, 32'hFFFF_FFFF, 1'b0);
        // R1 / R2: edge bits and both T values
        for (int t = 0; t < 2; t++) begin
            for (int op = 1; op <= 4; op++) begin
                drive(4'(op), 32'h8000_0001, 32'h0, 1'(t));
                drive(4'(op), 32'h4000_0002, 32'h0, 1'(t));
                drive(4'(op), 32'h0000_0000, 32'h0, 1'(t));
            end
        end
        // R3 / R4 / R5: one-bit and fixed shifts, T held high and low
        for (int t = 0; t < 2; t++) begin
            for (int op = 5; op <= 13; op++) begin
                drive(4'(op), 32'h8000_0001, 32'h0, 1'(t));
                drive(4'(op), 32'h7FFF_FFFE, 32'h0, 1'(t));
                drive(4'(op), 32'hA5C3_0F96, 32'h0, 1'(t));
            end
        end
        // R6: left amounts, including stray middle bits
        for (int op = 14; op <= 15; op++) begin
            drive(4'(op), 32'h8765_4321, 32'h0000_0000, 1'b1);
            drive(4'(op), 32'h8765_4321, 32'h0000_001F, 1'b0);
            drive(4'(op), 32'h8765_4321, 32'h7FFF_FFE3, 1'b1);
            // R7: right amounts -1, -31, with stray bits
            drive(4'(op), 32'h8765_4321, 32'hFFFF_FFFF, 1'b1);
            drive(4'(op), 32'h8765_4321, 32'hFFFF_FFE1, 1'b0);
            drive(4'(op), 32'h8765_4321, 32'h8000_0010, 1'b1);
            drive(4'(op), 32'h4765_4321, 32'hFFFF_FFF8, 1'b0);
            // R8: negative amount, low five bits zero
            drive(4'(op), 32'h8000_0000, 32'hFFFF_FFE0, 1'b1);
            drive(4'(op), 32'h7FFF_FFFF, 32'h8000_0000, 1'b0);
            drive(4'(op), 32'hFFFF_FFFF, 32'hC000_0020, 1'b1);
        end
        // sweep over all codes with varied words (R1..R10)
        x = 32'h1357_9BDF;
        for (int i = 0; i < 400; i++) begin
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            drive(x[3:0], x ^ 32'h5A5A_A5A5, {x[31], x[7:3], x[26:1]}, x[9]);
        end
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired before all items were checked");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule